// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

This block sits on the master side of a two-wire serial bus, above a byte-level engine that performs start conditions, stop conditions and single byte writes. After a write command to a serial memory has been closed with a stop, the memory runs an internally timed write cycle. While that cycle runs, the memory does not acknowledge its own address. The sequencer uses this to detect when the write has finished, so the master does not have to wait for a fixed worst-case write time.

A one-cycle `poll_start` captures the 7-bit device address and the `keep_bus` choice. The sequencer then runs poll attempts. Each attempt is a start condition followed by the control byte `{dev_addr, 0}`. When the slave gives no acknowledge, the sequencer closes the bus with a stop and tries again. When the slave acknowledges, the sequencer either leaves the bus open for the next command (`keep_bus=1`) or sends a stop first. It then pulses `done` with `ok`. If `MAX_TRIES` attempts in a row get no acknowledge, it sends a stop and pulses `done` with `timeout`.

Engine commands use these codes on `eng_cmd`: 0 is start, 1 is byte write, 2 is stop. A command is issued with `eng_cmd_valid` and is taken on a cycle where `eng_cmd_ready` is also high. The engine later reports completion with a one-cycle `eng_resp_valid`. For a byte write, `eng_resp_nack` is sampled with that response.

The FSM has these states:
- IDLE: waits for `poll_start`; on it, goes to SEND_START.
- SEND_START: offers the start command; on accept, goes to WAIT_START.
- WAIT_START: waits for the response; on it, goes to SEND_BYTE.
- SEND_BYTE: offers the control byte; on accept, goes to WAIT_BYTE.
- WAIT_BYTE: waits for the response. On an acknowledge with `keep_bus=1`, goes to FINISH. On an acknowledge with `keep_bus=0`, or on a no-acknowledge, goes to SEND_STOP.
- SEND_STOP: offers the stop command; on accept, goes to WAIT_STOP.
- WAIT_STOP: waits for the response. On a retry, goes back to SEND_START; otherwise goes to FINISH.
- FINISH: raises `done` for one cycle, then returns to IDLE.

Top module: `ack_poll_seq`

## Requirements
- R1: While reset is held and at its release, `busy`, `done`, `ok`, `timeout` and `eng_cmd_valid` are all low.
- R2: A `poll_start` seen in IDLE sets `busy` high from the next cycle. The first engine command after it is a start (code 0).
- R3: Every attempt is a start (code 0) followed by a byte write (code 1). The byte is `{captured address, 1'b0}`, with the read/write bit at bit 0 and equal to zero.
- R4: A byte write answered with no acknowledge, before the attempt limit is reached, is followed by a stop (code 2) and then a new start.
- R5: An acknowledged byte write with `keep_bus=0` is followed by one stop, and then by `done` with `ok=1` and `timeout=0`.
- R6: An acknowledged byte write with `keep_bus=1` leads to `done` with `ok=1` and no stop command.
- R7: After `MAX_TRIES` attempts that all get no acknowledge, the sequencer sends one stop and then `done` with `timeout=1` and `ok=0`, whatever `keep_bus` is.
- R8: `done` lasts exactly one cycle, and exactly one of `ok` and `timeout` is high during it. Both are low when `done` is low, and `busy` is low in the cycle after `done`.
- R9: `poll_start` and changes to `dev_addr` or `keep_bus` while `busy` is high have no effect. The bytes keep the captured address, and one `done` ends the operation.
- R10: A command held with `eng_cmd_ready` low stays valid with unchanged code and byte. No new command is offered until the previous one has received its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_start | input | 1 | One-cycle request to begin polling |
| dev_addr | input | 7 | 7-bit device address, captured at start |
| keep_bus | input | 1 | 1: leave the bus open after success; 0: send a stop |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok | output | 1 | Slave acknowledged (valid with done) |
| timeout | output | 1 | Attempt limit reached (valid with done) |
| eng_cmd_valid | output | 1 | Command offered to the byte engine |
| eng_cmd_ready | input | 1 | Engine accepts the offered command |
| eng_cmd | output | 2 | 0 start, 1 byte write, 2 stop |
| eng_wdata | output | 8 | Byte for a write command |
| eng_resp_valid | input | 1 | One-cycle command completion |
| eng_resp_nack | input | 1 | No acknowledge for a byte write |

## Verification
`busy` is sampled one cycle after the `poll_start` edge. Engine commands are sampled at the falling edge before the rising edge that accepts them, and the bench answers each one with a response 1 to 3 cycles later. `done` follows one cycle after the final response: the stop response, or the byte response when the bus is kept. The status is read in that `done` cycle, and the bench checks that `busy` and `done` are both low one cycle later. Command order, counts and byte values are logged at each accept edge and compared with counts that a bench function derives from the number of refused bytes, the `keep_bus` setting and the attempt limit.

// File: rtl/ap_pkg.sv
package ap_pkg;
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_STOP  = 2'd2
    } ap_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND_START,
        S_WAIT_START,
        S_SEND_BYTE,
        S_WAIT_BYTE,
        S_SEND_STOP,
        S_WAIT_STOP,
        S_FINISH
    } ap_state_e;
endpackage

// File: rtl/ap_try_counter.sv
module ap_try_counter #(
    parameter int MAX_TRIES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/ap_seq_fsm.sv
module ap_seq_fsm
    import ap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_start,
    input  logic [6:0] dev_addr,
    input  logic       keep_bus,
    input  logic       eng_cmd_ready,
    input  logic       eng_resp_valid,
    input  logic       eng_resp_nack,
    input  logic       try_last,
    output logic       try_clr,
    output logic       try_inc,
    output logic       busy,
    output logic       done,
    output logic       ok,
    output logic       timeout,
    output logic       eng_cmd_valid,
    output logic [1:0] eng_cmd,
    output logic [7:0] eng_wdata
);
    ap_state_e state_q, state_d;
    logic [6:0] addr_q;
    logic       keep_q;
    logic       ok_q;
    logic       retry_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request and attempt outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            keep_q  <= 1'b0;
            ok_q    <= 1'b0;
            retry_q <= 1'b0;
        end else if (state_q == S_IDLE && poll_start) begin
            addr_q  <= dev_addr;
            keep_q  <= keep_bus;
            ok_q    <= 1'b0;
            retry_q <= 1'b0;
        end else if (state_q == S_WAIT_BYTE && eng_resp_valid) begin
            ok_q    <= !eng_resp_nack;
            retry_q <= eng_resp_nack && !try_last;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (poll_start)     state_d = S_SEND_START;
            S_SEND_START: if (eng_cmd_ready)  state_d = S_WAIT_START;
            S_WAIT_START: if (eng_resp_valid) state_d = S_SEND_BYTE;
            S_SEND_BYTE:  if (eng_cmd_ready)  state_d = S_WAIT_BYTE;
            S_WAIT_BYTE:
                if (eng_resp_valid) begin
                    if (!eng_resp_nack && keep_q) state_d = S_FINISH;
                    else                          state_d = S_SEND_STOP;
                end
            S_SEND_STOP:  if (eng_cmd_ready)  state_d = S_WAIT_STOP;
            S_WAIT_STOP:
                if (eng_resp_valid) begin
                    state_d = retry_q ? S_SEND_START : S_FINISH;
                end
            S_FINISH:     state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_cmd_valid = 1'b0;
        eng_cmd       = CMD_START;
        unique case (state_q)
            S_SEND_START: begin eng_cmd_valid = 1'b1; eng_cmd = CMD_START; end
            S_SEND_BYTE:  begin eng_cmd_valid = 1'b1; eng_cmd = CMD_WRITE; end
            S_SEND_STOP:  begin eng_cmd_valid = 1'b1; eng_cmd = CMD_STOP;  end
            default:      ;
        endcase
        eng_wdata = {addr_q, 1'b0};
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        ok        = done && ok_q;
        timeout   = done && !ok_q;
        try_clr   = (state_q == S_IDLE) && poll_start;
        try_inc   = (state_q == S_WAIT_BYTE) && eng_resp_valid && eng_resp_nack;
    end
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
    parameter int MAX_TRIES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_start,
    input  logic [6:0] dev_addr,
    input  logic       keep_bus,
    output logic       busy,
    output logic       done,
    output logic       ok,
    output logic       timeout,
    output logic       eng_cmd_valid,
    input  logic       eng_cmd_ready,
    output logic [1:0] eng_cmd,
    output logic [7:0] eng_wdata,
    input  logic       eng_resp_valid,
    input  logic       eng_resp_nack
);
    logic try_clr;
    logic try_inc;
    logic try_last;

    ap_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (try_clr),
        .inc   (try_inc),
        .last  (try_last)
    );

    ap_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .poll_start     (poll_start),
        .dev_addr       (dev_addr),
        .keep_bus       (keep_bus),
        .eng_cmd_ready  (eng_cmd_ready),
        .eng_resp_valid (eng_resp_valid),
        .eng_resp_nack  (eng_resp_nack),
        .try_last       (try_last),
        .try_clr        (try_clr),
        .try_inc        (try_inc),
        .busy           (busy),
        .done           (done),
        .ok             (ok),
        .timeout        (timeout),
        .eng_cmd_valid  (eng_cmd_valid),
        .eng_cmd        (eng_cmd),
        .eng_wdata      (eng_wdata)
    );
endmodule

// File: rtl/ack_poll_seq_chk.sv
module ack_poll_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_start,
    input logic       busy,
    input logic       done,
    input logic       ok,
    input logic       timeout,
    input logic       eng_cmd_valid,
    input logic       eng_cmd_ready,
    input logic [1:0] eng_cmd,
    input logic [7:0] eng_wdata
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && poll_start) |=> busy);

    p_rw_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && eng_cmd == 2'd1) |-> (eng_wdata[0] == 1'b0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok != timeout));

    p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && !eng_cmd_ready) |=>
            (eng_cmd_valid && $stable(eng_cmd) && $stable(eng_wdata)));

    p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |-> busy);
endmodule

bind ack_poll_seq ack_poll_seq_chk u_chk (.*);

// File: tb/ack_poll_seq_test.sv
module ack_poll_seq_test;
    localparam int TRIES = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       poll_start = 1'b0;
    logic [6:0] dev_addr = '0;
    logic       keep_bus = 1'b0;
    logic       busy, done, ok, timeout;
    logic       eng_cmd_valid;
    logic       eng_cmd_ready = 1'b0;
    logic [1:0] eng_cmd;
    logic [7:0] eng_wdata;
    logic       eng_resp_valid = 1'b0;
    logic       eng_resp_nack = 1'b0;

    int total = 0;
    int bad = 0;

    // engine model state and log
    int  refuse_n = 0;
    int  n_start = 0, n_write = 0, n_stop = 0;
    int  wr_seen = 0;
    int  order_err = 0, byte_err = 0, overlap_err = 0;
    int  first_cmd = -1;
    int  last_cmd = 2;
    logic [7:0] exp_byte = '0;
    bit  pending = 0;
    bit  pend_nack = 0;
    int  pend_delay = 0;

    always #2 clk = ~clk;

    ack_poll_seq #(.MAX_TRIES(TRIES)) uut (.*);

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_starts(input int rn);
        return (rn >= TRIES) ? TRIES : rn + 1;
    endfunction

    function automatic int exp_stops(input int rn, input bit kp);
        if (rn >= TRIES) return TRIES;
        return rn + (kp ? 0 : 1);
    endfunction

    // byte engine model: acts at falling edges
    initial begin
        forever begin
            @(negedge clk);
            eng_resp_valid = 1'b0;
            eng_resp_nack  = 1'b0;
            if (!rst_n) begin
                pending = 0;
                eng_cmd_ready = 1'b0;
            end else if (pending) begin
                eng_cmd_ready = 1'b0;
                if (eng_cmd_valid) overlap_err++;
                if (pend_delay == 0) begin
                    eng_resp_valid = 1'b1;
                    eng_resp_nack  = pend_nack;
                    pending = 0;
                end else begin
                    pend_delay--;
                end
            end else begin
                eng_cmd_ready = ($urandom_range(0, 2) != 0);
                if (eng_cmd_valid && eng_cmd_ready) begin
                    if (first_cmd < 0) first_cmd = eng_cmd;
                    pend_nack = 1'b0;
                    case (eng_cmd)
                        2'd0: begin
                            n_start++;
                            if (last_cmd != 2 && last_cmd != 1) order_err++;
                        end
                        2'd1: begin
                            n_write++;
                            wr_seen++;
                            if (last_cmd != 0) order_err++;
                            if (eng_wdata != exp_byte) byte_err++;
                            pend_nack = (wr_seen <= refuse_n);
                        end
                        default: begin
                            n_stop++;
                            if (last_cmd != 1) order_err++;
                        end
                    endcase
                    last_cmd = eng_cmd;
                    pending = 1;
                    pend_delay = $urandom_range(0, 2);
                end
            end
        end
    end

    task automatic run_op(input logic [6:0] a, input bit kp, input int rn);
        int  cyc;
        bit  seen;
        int  dones;
        refuse_n = rn;
        n_start = 0; n_write = 0; n_stop = 0; wr_seen = 0;
        order_err = 0; byte_err = 0; overlap_err = 0;
        first_cmd = -1; last_cmd = 2;
        exp_byte = {a, 1'b0};
        @(negedge clk);
        dev_addr = a; keep_bus = kp; poll_start = 1'b1;
        @(negedge clk);
        poll_start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        @(negedge clk);
        // ignored request with different inputs while busy
        poll_start = 1'b1; dev_addr = ~a; keep_bus = ~kp;
        @(negedge clk);
        poll_start = 1'b0;
        seen = 0; dones = 0;
        for (cyc = 0; cyc < 3000 && !seen; cyc++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R8", "done reached", seen, 1);
        if (!seen) return;
        dones = 1;
        if (rn >= TRIES) begin
            chk(timeout == 1'b1 && ok == 1'b0, "R7", "timeout status", timeout, 1);
        end else if (kp) begin
            chk(ok == 1'b1 && timeout == 1'b0, "R6", "ok status kept bus", ok, 1);
        end else begin
            chk(ok == 1'b1 && timeout == 1'b0, "R5", "ok status with stop", ok, 1);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "done one cycle then idle",
            {done, busy}, 0);
        chk(ok == 1'b0 && timeout == 1'b0, "R8", "status low outside done",
            {ok, timeout}, 0);
        repeat (6) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(dones == 1, "R9", "single done per request", dones, 1);
        chk(first_cmd == 0, "R2", "first command is start", first_cmd, 0);
        chk(order_err == 0, "R3", "command order", order_err, 0);
        chk(byte_err == 0, "R9", "control byte keeps captured address", byte_err, 0);
        chk(n_start == exp_starts(rn) && n_write == exp_starts(rn), "R4",
            "attempt count", n_start, exp_starts(rn));
        if (rn >= TRIES)
            chk(n_stop == exp_stops(rn, kp), "R7", "stops on timeout", n_stop, exp_stops(rn, kp));
        else if (kp)
            chk(n_stop == exp_stops(rn, kp), "R6", "stops with kept bus", n_stop, exp_stops(rn, kp));
        else
            chk(n_stop == exp_stops(rn, kp), "R5", "stops with release", n_stop, exp_stops(rn, kp));
        chk(overlap_err == 0, "R10", "no command while response pending", overlap_err, 0);
    endtask

    initial begin
        void'($urandom(32'h1234_5a5a));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && ok == 0 && timeout == 0 && eng_cmd_valid == 0,
            "R1", "outputs in reset", {busy, done, ok, timeout, eng_cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && eng_cmd_valid == 0, "R1", "outputs after reset",
            {busy, done, eng_cmd_valid}, 0);
        // directed corners
        run_op(7'h50, 1'b0, 0);
        run_op(7'h51, 1'b1, 0);
        run_op(7'h2a, 1'b0, 3);
        run_op(7'h7f, 1'b1, TRIES - 1);
        run_op(7'h00, 1'b0, TRIES);
        run_op(7'h33, 1'b1, TRIES + 2);
        // random mix
        for (int i = 0; i < 24; i++) begin
            run_op(7'($urandom), 1'($urandom), $urandom_range(0, TRIES + 1));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule